// File: doc/BRIEF.md
# Wide Tick Counter with Torn-Read Detection

This block keeps a free-running counter that is twice as wide as the register port. It is read through two word-wide windows, one for the lower half and one for the upper half, plus a control word. A carry can move from the lower half into the upper half between the two reads. An exception or interrupt can also land between them. Either way, the value software assembles from the two halves may be torn. The block does not latch a snapshot. Instead, it watches the order of the reads and reports in the most significant bit of the control word whether the last pair was coherent.

Software reads the lower half, then the upper half, then the control word. It repeats the sequence until the coherence bit is 1. The counter runs only while the enable bit in the control word is set. The processor raises a one-cycle pulse whenever it takes an exception or interrupt, and the block uses it to invalidate a pair in progress.

Top module: `wide_tick_counter`

## Requirements
- R1: After synchronous reset the counter is zero, the enable is 0 and the coherence flag is 0, so the control word and both halves read as zero.
- R2: While enabled, the counter advances by one every clock and wraps to zero after all ones. A read at address 0x104 returns its lower word and a read at 0x105 returns its upper word, both combinationally in the read cycle.
- R3: A write to the control address 0x103 loads write-data bit 0 into the enable, which takes effect from the next cycle. Control reads return the enable in bit 0, the flag in bit WORD_W-1, and zeros elsewhere.
- R4: A read of the lower word starts tracking a new pair and sets the coherence flag from the next cycle.
- R5: A read of the upper word that follows a lower-word read, with no invalidating event between them, leaves the flag at 1.
- R6: An exception pulse in any cycle after the lower-word read, up to and including the upper-word read cycle, clears the flag.
- R7: If the upper word at the upper-word read differs from its value in the lower-word read cycle, the flag is cleared. This includes a carry taken on the same edge as the lower-word read.
- R8: A read of the upper word that is not preceded by a lower-word read since the last upper-word read clears the flag.
- R9: Writes to the two counter windows or to unmapped addresses change nothing. Unmapped reads return zero. Control-word reads do not disturb a pair in progress.
- R10: While the enable is 0, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe for the register port |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Register address |
| wdata | input | WORD_W | Write data |
| exc_taken | input | 1 | One-cycle pulse: exception or interrupt taken |
| rdata | output | WORD_W | Read data, valid in the cycle rd_en is high, zero otherwise |

## Verification
The bench builds the block with WORD_W set to 8, which gives a 16-bit counter. At that width a carry into the upper word comes every 256 cycles, so the bench can aim lower-word reads at the carry, including on the carry edge itself. A full wrap of the counter also fits into the run. Random sequences of reads, writes and exception pulses run alongside a bench model of the pair tracking.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int unsigned DEF_ADDR_W = 12;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_HIGH = 2'd3
    } wtc_sel_e;

    typedef struct packed {
        logic rd_low;
        logic rd_high;
        logic wr_ctrl;
    } wtc_acc_t;

    function automatic wtc_sel_e pick_sel(input logic hit_c, input logic hit_l,
                                          input logic hit_h);
        if (hit_c)      return SEL_CTRL;
        else if (hit_l) return SEL_LOW;
        else if (hit_h) return SEL_HIGH;
        else            return SEL_NONE;
    endfunction

    function automatic wtc_acc_t make_acc(input wtc_sel_e sel, input logic rd,
                                          input logic wr);
        wtc_acc_t a;
        a.rd_low  = rd && (sel == SEL_LOW);
        a.rd_high = rd && (sel == SEL_HIGH);
        a.wr_ctrl = wr && (sel == SEL_CTRL);
        return a;
    endfunction

endpackage

// File: rtl/wtc_count.sv
module wtc_count #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             en_bit,
    output logic [CNT_W-1:0] cnt,
    output logic             en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            en  <= 1'b0;
        end else begin
            if (en)      cnt <= cnt + 1'b1;
            if (wr_ctrl) en  <= en_bit;
        end
    end
endmodule

// File: rtl/wtc_tear_mon.sv
module wtc_tear_mon #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_low,
    input  logic              rd_high,
    input  logic              exc,
    input  logic [WORD_W-1:0] cnt_hi,
    output logic              flag,
    output logic              armed,
    output logic [WORD_W-1:0] snap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
            snap  <= '0;
        end else if (rd_low) begin
            flag  <= 1'b1;
            armed <= 1'b1;
            snap  <= cnt_hi;
        end else if (rd_high) begin
            armed <= 1'b0;
            flag  <= armed && flag && !exc && (cnt_hi == snap);
        end else if (armed && exc) begin
            flag  <= 1'b0;
        end
    end
endmodule

// File: rtl/wtc_regmux.sv
module wtc_regmux
    import wtc_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
    parameter logic [ADDR_W-1:0] LOW_ADDR  = 'h104,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 'h105
) (
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*WORD_W-1:0] cnt,
    input  logic                en,
    input  logic                flag,
    output wtc_acc_t            acc,
    output logic [WORD_W-1:0]   rdata
);
    wtc_sel_e sel;

    always_comb begin
        sel = pick_sel(addr == CTRL_ADDR, addr == LOW_ADDR, addr == HIGH_ADDR);
        acc = make_acc(sel, rd_en, wr_en);
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    rdata[0]        = en;
                    rdata[WORD_W-1] = flag;
                end
                SEL_LOW:  rdata = cnt[WORD_W-1:0];
                SEL_HIGH: rdata = cnt[2*WORD_W-1:WORD_W];
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wide_tick_counter.sv
module wide_tick_counter
    import wtc_pkg::*;
#(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
    parameter logic [ADDR_W-1:0] LOW_ADDR  = 'h104,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 'h105
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              exc_taken,
    output logic [WORD_W-1:0] rdata
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    wtc_acc_t          acc;
    logic [CNT_W-1:0]  cnt;
    logic              en;
    logic              flag;
    logic              armed;
    logic [WORD_W-1:0] snap;

    wtc_regmux #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W),
        .CTRL_ADDR(CTRL_ADDR), .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR)
    ) u_mux (
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .cnt(cnt), .en(en),
        .flag(flag), .acc(acc), .rdata(rdata)
    );

    wtc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .wr_ctrl(acc.wr_ctrl), .en_bit(wdata[0]),
        .cnt(cnt), .en(en)
    );

    wtc_tear_mon #(.WORD_W(WORD_W)) u_mon (
        .clk(clk), .rst(rst), .rd_low(acc.rd_low), .rd_high(acc.rd_high),
        .exc(exc_taken), .cnt_hi(cnt[CNT_W-1:WORD_W]), .flag(flag),
        .armed(armed), .snap(snap)
    );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h103,
    parameter logic [ADDR_W-1:0] LOW_ADDR  = 'h104,
    parameter logic [ADDR_W-1:0] HIGH_ADDR = 'h105
) (
    input logic                clk,
    input logic                rst,
    input logic                rd_en,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic                exc_taken,
    input logic [2*WORD_W-1:0] cnt,
    input logic                en,
    input logic                flag,
    input logic                armed,
    input logic [WORD_W-1:0]   snap
);
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    logic rd_lo, rd_hi;
    assign rd_lo = rd_en && (addr == LOW_ADDR);
    assign rd_hi = rd_en && (addr == HIGH_ADDR);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!live) |-> (cnt == '0 && !en && !flag)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (live && en) |=> (cnt == $past(cnt) + 1'b1)); // R2

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (live && !en) |=> $stable(cnt)); // R10

    AST_LOW_ARMS: assert property (@(posedge clk) disable iff (rst)
        rd_lo |=> (flag && armed)); // R4

    AST_EXC_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (armed && exc_taken && !rd_lo) |=> !flag); // R6

    AST_CARRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && cnt[2*WORD_W-1:WORD_W] != snap) |=> !flag); // R7

    AST_LONE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && !armed) |=> !flag); // R8

    AST_ODD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (live && wr_en && addr != CTRL_ADDR) |=> $stable(en)); // R9
endmodule

bind wide_tick_counter wtc_checker #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .CTRL_ADDR(CTRL_ADDR), .LOW_ADDR(LOW_ADDR), .HIGH_ADDR(HIGH_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .exc_taken(exc_taken), .cnt(cnt), .en(en), .flag(flag), .armed(armed),
    .snap(snap)
);

// File: tb/wide_tick_counter_test.sv
module wide_tick_counter_test;
    localparam int W  = 8;
    localparam int AW = 12;
    localparam logic [AW-1:0] A_CTRL = 12'h103;
    localparam logic [AW-1:0] A_LOW  = 12'h104;
    localparam logic [AW-1:0] A_HIGH = 12'h105;
    localparam logic [AW-1:0] A_NONE = 12'h200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rd_en = 1'b0, wr_en = 1'b0, exc_taken = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    logic [2*W-1:0] m_cnt = '0;
    logic           m_en = 0, m_flag = 0, m_armed = 0;
    logic [W-1:0]   m_snap = '0;

    always #4 clk = ~clk;

    wide_tick_counter #(.WORD_W(W), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .exc_taken(exc_taken), .rdata(rdata)
    );

    function automatic logic [W-1:0] exp_read(input logic [AW-1:0] a);
        logic [W-1:0] v = '0;
        if (a == A_LOW)       v = m_cnt[W-1:0];
        else if (a == A_HIGH) v = m_cnt[2*W-1:W];
        else if (a == A_CTRL) begin v[0] = m_en; v[W-1] = m_flag; end
        return v;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic rd, input logic wr, input logic [AW-1:0] a,
                       input logic [W-1:0] wd, input logic ex, input string tag);
        @(negedge clk);
        rd_en = rd; wr_en = wr; addr = a; wdata = wd; exc_taken = ex;
        #1;
        if (rd) check(tag, rdata, exp_read(a));
        @(posedge clk);
        if (rd && a == A_LOW) begin
            m_flag = 1; m_armed = 1; m_snap = m_cnt[2*W-1:W];
        end else if (rd && a == A_HIGH) begin
            m_flag = m_armed && m_flag && !ex && (m_cnt[2*W-1:W] == m_snap);
            m_armed = 0;
        end else if (m_armed && ex) m_flag = 0;
        if (m_en) m_cnt = m_cnt + 1'b1;
        if (wr && a == A_CTRL) m_en = wd[0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, A_NONE, '0, 0, "");
    endtask

    task automatic wait_low(input logic [W-1:0] v);
        while (m_cnt[W-1:0] != v) cyc(0, 0, A_NONE, '0, 0, "");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        cyc(1, 0, A_CTRL, '0, 0, "R1");
        cyc(1, 0, A_HIGH, '0, 0, "R1");
        cyc(1, 0, A_CTRL, '0, 0, "R8");
        // R10 disabled hold
        idle(5);
        cyc(1, 0, A_LOW, '0, 0, "R10");
        // R3 enable
        cyc(0, 1, A_CTRL, 8'h01, 0, "");
        cyc(1, 0, A_CTRL, '0, 0, "R3");
        idle(3);
        cyc(1, 0, A_LOW, '0, 0, "R2");
        // R4, R5
        cyc(1, 0, A_CTRL, '0, 0, "R4");
        cyc(1, 0, A_HIGH, '0, 0, "R5");
        cyc(1, 0, A_CTRL, '0, 0, "R5");
        cyc(1, 0, A_LOW, '0, 0, "R4");
        cyc(1, 0, A_CTRL, '0, 0, "R4");
        // R6 exceptions
        cyc(1, 0, A_LOW, '0, 0, "R6");
        cyc(0, 0, A_NONE, '0, 1, "");
        cyc(1, 0, A_HIGH, '0, 0, "R6");
        cyc(1, 0, A_CTRL, '0, 0, "R6");
        cyc(1, 0, A_LOW, '0, 0, "R6");
        cyc(1, 0, A_HIGH, '0, 1, "R6");
        cyc(1, 0, A_CTRL, '0, 0, "R6");
        // R7 carry between reads and on the read edge
        wait_low(8'hFE);
        cyc(1, 0, A_LOW, '0, 0, "R7");
        idle(1);
        cyc(1, 0, A_HIGH, '0, 0, "R7");
        cyc(1, 0, A_CTRL, '0, 0, "R7");
        wait_low(8'hFF);
        cyc(1, 0, A_LOW, '0, 0, "R7");
        cyc(1, 0, A_HIGH, '0, 0, "R7");
        cyc(1, 0, A_CTRL, '0, 0, "R7");
        // R8 repeated high read
        cyc(1, 0, A_LOW, '0, 0, "R8");
        cyc(1, 0, A_HIGH, '0, 0, "R8");
        cyc(1, 0, A_HIGH, '0, 0, "R8");
        cyc(1, 0, A_CTRL, '0, 0, "R8");
        // R9 ignored writes, unmapped reads, control read inside pair
        cyc(0, 1, A_LOW, 8'h00, 0, "");
        cyc(0, 1, A_HIGH, 8'h00, 0, "");
        cyc(0, 1, A_NONE, 8'h00, 0, "");
        cyc(1, 0, A_CTRL, '0, 0, "R9");
        cyc(1, 0, A_NONE, '0, 0, "R9");
        cyc(1, 0, A_LOW, '0, 0, "R9");
        cyc(1, 0, A_CTRL, '0, 0, "R9");
        cyc(1, 0, A_HIGH, '0, 0, "R9");
        cyc(1, 0, A_CTRL, '0, 0, "R9");
        // R10 disable and stray write
        cyc(0, 1, A_CTRL, 8'h00, 0, "");
        cyc(0, 1, A_LOW, 8'hFF, 0, "");
        cyc(1, 0, A_LOW, '0, 0, "R10");
        idle(4);
        cyc(1, 0, A_LOW, '0, 0, "R10");
        cyc(1, 0, A_HIGH, '0, 0, "R10");
        cyc(0, 1, A_CTRL, 8'h01, 0, "");
        // random mix
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] pick = 4'($urandom_range(0, 15));
            logic [AW-1:0] a;
            logic rd, wr;
            logic [W-1:0] wd;
            string tg;
            a  = (pick < 5) ? A_LOW : (pick < 10) ? A_HIGH : (pick < 14) ? A_CTRL : A_NONE;
            rd = ($urandom_range(0, 3) != 0);
            wr = ($urandom_range(0, 15) == 0);
            wd = 8'($urandom);
            if (a == A_CTRL && $urandom_range(0, 3) != 0) wd[0] = 1'b1;
            tg = (a == A_CTRL) ? "R5" : (a == A_NONE) ? "R9" : "R2";
            cyc(rd, wr, a, wd, ($urandom_range(0, 15) == 0), tg);
        end
        // R2 wrap of the full counter
        cyc(0, 1, A_CTRL, 8'h01, 0, "");
        while (m_cnt != 16'hFFFE) cyc(0, 0, A_NONE, '0, 0, "");
        cyc(1, 0, A_LOW, '0, 0, "R2");
        cyc(1, 0, A_HIGH, '0, 0, "R2");
        cyc(1, 0, A_LOW, '0, 0, "R2");
        cyc(1, 0, A_HIGH, '0, 0, "R2");
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule